// File: doc/BRIEF.md
# Interrupt Vector Mapper with Conflict Policy

This block sits between peripheral interrupt sources and a processor. Each cycle it may receive a raw request value with a valid strobe. A nonzero value is turned into a processor interrupt vector. The vector comes either from a small programmable key/vector table or, with translation off, from the value itself. The block holds one pending vector and keeps offering it to the processor until the processor acknowledges it.

A request that maps to a vector different from the one still pending is a conflict. A programmable policy resolves it: raise a fatal error, replace the pending vector with the new one, or replace it with a fixed substitute vector. Fatal conditions, a conflict under the abort policy or a table miss, set a sticky error output. The event that caused the error is dropped.

Configuration is a simple write port. With DEPTH = 8 the address is 4 bits wide. Addresses 0..DEPTH-1 (top address bit 0) write table entry `cfgAddr[2:0]`. The write data is `{key, vector}`, with the key in the upper VAL_W bits and the vector in the lower VEC_W bits. Address 8 writes the control register, where bits [1:0] hold the policy and bit 2 enables translation. Address 9 writes the substitute vector into bits [VEC_W-1:0]. All other addresses are ignored.

Top module: `irq_vec_mapper`

## Requirements
- R1: A request whose value is zero changes nothing: the pending vector, the request output and the error flag keep their values.
- R2: With translation disabled (control bit 2 = 0), a nonzero request value is used directly as the vector.
- R3: With translation enabled, the vector comes from the lowest-indexed table entry whose key equals the value. Only entries before the first entry with key 0 are searched. A matched vector of 0 drops the event.
- R4: With translation enabled, a value that matches no searched entry sets the error flag and is dropped, leaving the pending vector unchanged.
- R5: A mapped vector equal to the one already pending is discarded without side effects.
- R6: Policy 0 (abort, also the value after reset; policy 3 behaves the same): a different vector arriving while one is pending sets the error flag and leaves the pending vector unchanged.
- R7: Policy 1 (replace): a different vector arriving while one is pending replaces it.
- R8: Policy 2 (substitute): a different vector arriving while one is pending replaces it with the configured substitute vector.
- R9: `cpuReq` is high exactly when the pending vector is nonzero, and `cpuVec` shows the pending vector. The vector is held until `cpuAck` is seen with `cpuReq` high, and then it is cleared to zero.
- R10: If an acknowledge and a new vector are processed in the same cycle, the acknowledge retires the old vector and the new one becomes pending. No conflict policy applies, and no error is raised.
- R11: A request sampled at clock edge k appears on `cpuVec`/`cpuReq` after edge k+1, one cycle later.
- R12: The error flag is sticky until reset. Reset clears the pending vector, the error flag, the table keys and the substitute vector, and selects policy 0 with translation off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request value strobe |
| reqValue | input | VAL_W | Raw request value from a source |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | clog2(DEPTH)+1 | Configuration address (table entries, control, substitute) |
| cfgWrData | input | VAL_W+VEC_W | Configuration write data |
| cpuAck | input | 1 | Processor accepts the offered vector |
| cpuReq | output | 1 | A vector is pending |
| cpuVec | output | VEC_W | Pending vector |
| errFatal | output | 1 | Sticky fatal error |

## Verification
The assertions assume that the processor raises `cpuAck` only while `cpuReq` is high. The bench drives the acknowledge only after it has seen a pending vector. The hold and stability properties also assume that configuration writes do not race events already in flight. The bench therefore writes the table and registers only when no request is in the input stage. Sweeps cover every 8-bit value in pass-through mode and every key against a table that contains a duplicate key and an entry past its terminator. After each expected fatal error the bench resets and reprograms the block, so the sticky flag cannot mask the next case.

// File: rtl/ivm_pkg.sv
package ivm_pkg;
  localparam logic [1:0] POL_ABORT   = 2'd0;
  localparam logic [1:0] POL_REPLACE = 2'd1;
  localparam logic [1:0] POL_SUBST   = 2'd2;

  typedef struct packed {
    logic loadPending;
    logic selSubst;
    logic clearPending;
    logic setErr;
  } ctrl_strobe_t;
endpackage

// File: rtl/ivm_table.sv
module ivm_table #(
  parameter int VAL_W = 8,
  parameter int VEC_W = 8,
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [VAL_W-1:0] wrKey,
  input  logic [VEC_W-1:0] wrVec,
  input  logic [VAL_W-1:0] lookKey,
  output logic             hit,
  output logic [VEC_W-1:0] hitVec
);
  logic [VAL_W-1:0] keyQ [DEPTH];
  logic [VEC_W-1:0] vecQ [DEPTH];
  logic [DEPTH-1:0] live;
  logic [DEPTH-1:0] match;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        keyQ[i] <= '0;
        vecQ[i] <= '0;
      end
    end else if (wrEn) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wrIdx == IDX_W'(i)) begin
          keyQ[i] <= wrKey;
          vecQ[i] <= wrVec;
        end
      end
    end
  end

  // An entry is searched only if no earlier entry holds the zero terminator.
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      if (i == 0) begin : g_first
        assign live[i] = (keyQ[i] != '0);
      end else begin : g_rest
        assign live[i] = live[i-1] && (keyQ[i] != '0);
      end
      assign match[i] = live[i] && (keyQ[i] == lookKey);
    end
  endgenerate

  always_comb begin
    hit    = |match;
    hitVec = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) hitVec = vecQ[i];
    end
  end
endmodule

// File: rtl/ivm_datapath.sv
module ivm_datapath
  import ivm_pkg::*;
#(
  parameter int VAL_W = 8,
  parameter int VEC_W = 8,
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CFG_ADDR_W = IDX_W + 1,
  localparam int CFG_DATA_W = VAL_W + VEC_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [VAL_W-1:0]      reqValue,
  input  logic                  cfgWrEn,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic [CFG_DATA_W-1:0] cfgWrData,
  input  ctrl_strobe_t          strobe,
  output logic                  evValid,
  output logic [VEC_W-1:0]      mappedVec,
  output logic                  mapMiss,
  output logic [VEC_W-1:0]      pendingVec,
  output logic [1:0]            policy,
  output logic                  cpuReq,
  output logic [VEC_W-1:0]      cpuVec
);
  logic             evValidQ;
  logic [VAL_W-1:0] evValueQ;
  logic [1:0]       policyQ;
  logic             xlateQ;
  logic [VEC_W-1:0] substQ;
  logic [VEC_W-1:0] pendingQ;
  logic [VEC_W-1:0] rawVec;
  logic [VEC_W-1:0] tblVec;
  logic             tblHit;
  logic             isCtrlSpace;
  logic             tblWr;
  logic             ctrlWr;
  logic             substWr;

  // Input stage: only nonzero values count as events.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evValidQ <= 1'b0;
      evValueQ <= '0;
    end else begin
      evValidQ <= reqValid && (reqValue != '0);
      if (reqValid && (reqValue != '0)) evValueQ <= reqValue;
    end
  end

  // Configuration decode.
  assign isCtrlSpace = cfgAddr[CFG_ADDR_W-1];
  assign tblWr   = cfgWrEn && !isCtrlSpace;
  assign ctrlWr  = cfgWrEn && isCtrlSpace && (cfgAddr[IDX_W-1:0] == IDX_W'(0));
  assign substWr = cfgWrEn && isCtrlSpace && (cfgAddr[IDX_W-1:0] == IDX_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      policyQ <= POL_ABORT;
      xlateQ  <= 1'b0;
      substQ  <= '0;
    end else begin
      if (ctrlWr) begin
        policyQ <= cfgWrData[1:0];
        xlateQ  <= cfgWrData[2];
      end
      if (substWr) substQ <= cfgWrData[VEC_W-1:0];
    end
  end

  ivm_table #(
    .VAL_W(VAL_W),
    .VEC_W(VEC_W),
    .DEPTH(DEPTH)
  ) u_table (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (tblWr),
    .wrIdx  (cfgAddr[IDX_W-1:0]),
    .wrKey  (cfgWrData[CFG_DATA_W-1 -: VAL_W]),
    .wrVec  (cfgWrData[VEC_W-1:0]),
    .lookKey(evValueQ),
    .hit    (tblHit),
    .hitVec (tblVec)
  );

  generate
    if (VAL_W >= VEC_W) begin : g_rawTrunc
      assign rawVec = evValueQ[VEC_W-1:0];
    end else begin : g_rawPad
      assign rawVec = {{(VEC_W - VAL_W){1'b0}}, evValueQ};
    end
  endgenerate

  assign mappedVec = xlateQ ? tblVec : rawVec;
  assign mapMiss   = xlateQ && !tblHit;
  assign evValid   = evValidQ;
  assign policy    = policyQ;

  // Pending vector register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingQ <= '0;
    end else if (strobe.loadPending) begin
      pendingQ <= strobe.selSubst ? substQ : mappedVec;
    end else if (strobe.clearPending) begin
      pendingQ <= '0;
    end
  end

  assign pendingVec = pendingQ;
  assign cpuVec     = pendingQ;
  assign cpuReq     = (pendingQ != '0);
endmodule

// File: rtl/ivm_control.sv
module ivm_control
  import ivm_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evValid,
  input  logic [VEC_W-1:0] mappedVec,
  input  logic             mapMiss,
  input  logic [VEC_W-1:0] pendingVec,
  input  logic [1:0]       policy,
  input  logic             cpuAck,
  output ctrl_strobe_t     strobe,
  output logic             errFatal
);
  logic ackTaken;
  logic busy;
  logic errQ;

  assign ackTaken = cpuAck && (pendingVec != '0);
  // Pending slot still occupied after this cycle's acknowledge.
  assign busy     = (pendingVec != '0) && !ackTaken;

  always_comb begin
    strobe              = '0;
    strobe.clearPending = ackTaken;
    if (evValid) begin
      if (mapMiss) begin
        strobe.setErr = 1'b1;
      end else if (mappedVec == '0) begin
        // Table entry mapping to vector zero: event dropped.
      end else if (!busy) begin
        strobe.loadPending = 1'b1;
      end else if (mappedVec == pendingVec) begin
        // Duplicate of the pending vector: discarded.
      end else begin
        case (policy)
          POL_REPLACE: strobe.loadPending = 1'b1;
          POL_SUBST: begin
            strobe.loadPending = 1'b1;
            strobe.selSubst    = 1'b1;
          end
          default: strobe.setErr = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errQ <= 1'b0;
    else if (strobe.setErr) errQ <= 1'b1;
  end

  assign errFatal = errQ;
endmodule

// File: rtl/irq_vec_mapper.sv
module irq_vec_mapper
  import ivm_pkg::*;
#(
  parameter int VAL_W = 8,
  parameter int VEC_W = 8,
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CFG_ADDR_W = IDX_W + 1,
  localparam int CFG_DATA_W = VAL_W + VEC_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [VAL_W-1:0]      reqValue,
  input  logic                  cfgWrEn,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic [CFG_DATA_W-1:0] cfgWrData,
  input  logic                  cpuAck,
  output logic                  cpuReq,
  output logic [VEC_W-1:0]      cpuVec,
  output logic                  errFatal
);
  ctrl_strobe_t     strobe;
  logic             evValid;
  logic [VEC_W-1:0] mappedVec;
  logic             mapMiss;
  logic [VEC_W-1:0] pendingVec;
  logic [1:0]       policy;

  ivm_datapath #(
    .VAL_W(VAL_W),
    .VEC_W(VEC_W),
    .DEPTH(DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqValue  (reqValue),
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .strobe    (strobe),
    .evValid   (evValid),
    .mappedVec (mappedVec),
    .mapMiss   (mapMiss),
    .pendingVec(pendingVec),
    .policy    (policy),
    .cpuReq    (cpuReq),
    .cpuVec    (cpuVec)
  );

  ivm_control #(
    .VEC_W(VEC_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .evValid   (evValid),
    .mappedVec (mappedVec),
    .mapMiss   (mapMiss),
    .pendingVec(pendingVec),
    .policy    (policy),
    .cpuAck    (cpuAck),
    .strobe    (strobe),
    .errFatal  (errFatal)
  );
endmodule

// File: rtl/ivm_checker.sv
module ivm_checker #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cpuAck,
  input logic             cpuReq,
  input logic [VEC_W-1:0] cpuVec,
  input logic             errFatal,
  input logic             evValid
);
  assert_req_tracks_vec_R9: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq == (cpuVec != '0));

  assert_ack_only_with_req_R9: assert property (@(posedge clk) disable iff (!rstN)
    cpuAck |-> cpuReq);

  assert_pending_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && !cpuAck |=> cpuReq);

  assert_idle_input_no_change_R1: assert property (@(posedge clk) disable iff (!rstN)
    !evValid && !cpuAck |=> $stable(cpuVec));

  assert_ack_retires_R9: assert property (@(posedge clk) disable iff (!rstN)
    cpuAck && cpuReq && !evValid |=> !cpuReq);

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    errFatal |=> errFatal);

  assert_err_keeps_pending_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFatal) && !$past(cpuAck) |-> $stable(cpuVec));
endmodule

bind irq_vec_mapper ivm_checker #(.VEC_W(VEC_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cpuAck  (cpuAck),
  .cpuReq  (cpuReq),
  .cpuVec  (cpuVec),
  .errFatal(errFatal),
  .evValid (evValid)
);

// File: tb/irq_vec_mapper_tb.sv
module irq_vec_mapper_tb;
  localparam int VAL_W = 8;
  localparam int VEC_W = 8;
  localparam int DEPTH = 8;
  localparam logic [3:0] ADDR_CTRL  = 4'd8;
  localparam logic [3:0] ADDR_SUBST = 4'd9;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic [VAL_W-1:0] reqValue = '0;
  logic             cfgWrEn = 1'b0;
  logic [3:0]       cfgAddr = '0;
  logic [15:0]      cfgWrData = '0;
  logic             cpuAck = 1'b0;
  logic             cpuReq;
  logic [VEC_W-1:0] cpuVec;
  logic             errFatal;

  int checks = 0;
  int failures = 0;

  logic [7:0] tbKey [DEPTH];
  logic [7:0] tbVec [DEPTH];

  always #10 clk = ~clk;

  irq_vec_mapper #(.VAL_W(VAL_W), .VEC_W(VEC_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqValue(reqValue),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .cpuAck(cpuAck), .cpuReq(cpuReq), .cpuVec(cpuVec), .errFatal(errFatal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic checkOut(input string tag, input logic [7:0] expVec, input logic expErr);
    chk({tag, " vec"}, 32'(cpuVec), 32'(expVec));
    chk({tag, " req"}, 32'(cpuReq), 32'(expVec != 0));
    chk({tag, " err"}, 32'(errFatal), 32'(expErr));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic sendEv(input logic [7:0] v);
    @(negedge clk);
    reqValid = 1'b1;
    reqValue = v;
    @(negedge clk);
    reqValid = 1'b0;
    reqValue = '0;
    @(negedge clk);
  endtask

  task automatic doAck();
    @(negedge clk);
    cpuAck = 1'b1;
    @(negedge clk);
    cpuAck = 1'b0;
  endtask

  task automatic cfgWrite(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgAddr = a;
    cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic programTable();
    for (int i = 0; i < DEPTH; i++) cfgWrite(4'(i), {tbKey[i], tbVec[i]});
    cfgWrite(ADDR_CTRL, 16'h0004);
  endtask

  // Lookup from the table contents as R3 describes: stop at the first zero key.
  task automatic expLookup(input logic [7:0] k, output logic hit, output logic [7:0] v);
    hit = 1'b0;
    v = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (tbKey[i] == 0) break;
      if (!hit && tbKey[i] == k) begin
        hit = 1'b1;
        v = tbVec[i];
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // Table: duplicate key 2 at entry 5, terminator at entry 6, key 9 past it.
    tbKey[0] = 8'd1; tbKey[1] = 8'd2; tbKey[2] = 8'd3; tbKey[3] = 8'd4;
    tbKey[4] = 8'd5; tbKey[5] = 8'd2; tbKey[6] = 8'd0; tbKey[7] = 8'd9;
    for (int i = 0; i < DEPTH; i++) tbVec[i] = 8'h40 + 8'(i);

    doReset();
    checkOut("R12 reset", 8'h00, 1'b0);

    // R11 latency
    @(negedge clk);
    reqValid = 1'b1;
    reqValue = 8'h21;
    @(negedge clk);
    reqValid = 1'b0;
    reqValue = '0;
    chk("R11 not yet visible", 32'(cpuReq), 32'd0);
    @(negedge clk);
    chk("R11 visible after second edge", 32'(cpuVec), 32'h21);
    doAck();
    checkOut("R9 ack clears", 8'h00, 1'b0);

    // R1 zero value with nothing pending and with something pending
    sendEv(8'h00);
    checkOut("R1 zero idle", 8'h00, 1'b0);
    sendEv(8'h33);
    sendEv(8'h00);
    checkOut("R1 zero while pending", 8'h33, 1'b0);
    // R9 held over idle cycles
    repeat (5) @(negedge clk);
    checkOut("R9 held until ack", 8'h33, 1'b0);
    // R5 duplicate
    sendEv(8'h33);
    checkOut("R5 duplicate discarded", 8'h33, 1'b0);
    doAck();
    checkOut("R5 single delivery", 8'h00, 1'b0);

    // R2 sweep of every nonzero value, translation off
    for (int v = 1; v < 256; v++) begin
      sendEv(8'(v));
      checkOut("R2 pass-through", 8'(v), 1'b0);
      doAck();
      chk("R9 cleared after ack", 32'(cpuReq), 32'd0);
    end

    // R10 ack and new different vector together, abort policy
    sendEv(8'h03);
    @(negedge clk);
    reqValid = 1'b1;
    reqValue = 8'h07;
    @(negedge clk);
    reqValid = 1'b0;
    reqValue = '0;
    cpuAck = 1'b1;
    @(negedge clk);
    cpuAck = 1'b0;
    checkOut("R10 ack with new vector", 8'h07, 1'b0);
    doAck();

    // R6 abort default
    sendEv(8'h03);
    sendEv(8'h07);
    checkOut("R6 abort keeps pending", 8'h03, 1'b1);
    doAck();
    sendEv(8'h11);
    checkOut("R12 error sticky", 8'h11, 1'b1);
    doReset();
    checkOut("R12 reset clears error", 8'h00, 1'b0);

    // R6 policy 3 behaves as abort
    cfgWrite(ADDR_CTRL, 16'h0003);
    sendEv(8'h03);
    sendEv(8'h07);
    checkOut("R6 policy3 aborts", 8'h03, 1'b1);
    doReset();

    // R7 replace
    cfgWrite(ADDR_CTRL, 16'h0001);
    sendEv(8'h03);
    sendEv(8'h07);
    checkOut("R7 replace", 8'h07, 1'b0);
    sendEv(8'h07);
    checkOut("R7 then duplicate", 8'h07, 1'b0);
    doAck();

    // R8 substitute
    cfgWrite(ADDR_CTRL, 16'h0002);
    cfgWrite(ADDR_SUBST, 16'h002A);
    sendEv(8'h03);
    sendEv(8'h07);
    checkOut("R8 substitute", 8'h2A, 1'b0);
    doAck();
    checkOut("R8 acked", 8'h00, 1'b0);

    // R3/R4 sweep of every key against the table
    doReset();
    programTable();
    for (int k = 1; k < 256; k++) begin
      logic hit;
      logic [7:0] ev;
      expLookup(8'(k), hit, ev);
      sendEv(8'(k));
      if (hit) begin
        checkOut("R3 table lookup", ev, 1'b0);
        doAck();
      end else begin
        checkOut("R4 table miss", 8'h00, 1'b1);
        doReset();
        programTable();
      end
    end

    // R4 miss with a vector pending leaves it
    sendEv(8'd4);
    sendEv(8'd9);
    checkOut("R4 miss keeps pending", 8'h43, 1'b1);
    doReset();

    // R3 zero vector in the table drops the event
    cfgWrite(4'd0, 16'h0500);
    cfgWrite(ADDR_CTRL, 16'h0004);
    sendEv(8'd5);
    checkOut("R3 zero vector dropped", 8'h00, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule